// File: doc/BRIEF.md
# Implied and Stack Bus-Cycle Sequencer

This block sets the order of bus cycles for the part of an 8-bit accumulator CPU that covers single-byte register operations, stack pushes and pulls, subroutine call and return, return from interrupt and the software interrupt. On each cycle it drives one bus action: an opcode fetch, a discarded read, an operand read, a stack write, a stack read or a vector read. For every action it also drives the address, the read and write strobes and the write data. A one-cycle done pulse marks the last cycle of each instruction.

The block fetches the opcode at the program counter. During that fetch cycle an external decoder presents a 4-bit instruction class taken from the fetched byte. Memory is a plain port. Read data must be valid in the same cycle as the address, and a write takes effect on the clock edge. The accumulator and status values come in on inputs so they can be pushed. When a pulled byte is meant for the accumulator or the status register, a load strobe is raised in the cycle that byte sits on the read data bus.

Each class has a fixed pattern of dead cycles, and the pattern holds however many bytes the class moves. Every instruction spends the cycle after its fetch on a read of the following byte. Every pull first spends one idle read at the stack. A subroutine return spends one more read at the return address before it moves past that address.

Top module: `stack_seq`

## Requirements
- R1: While reset is low, the program counter output holds RESET_PC, the stack pointer output holds RESET_SP and no write is driven. The first cycle after release is an opcode fetch at RESET_PC.
- R2: Every instruction takes at least two cycles. The cycle after a fetch at address N is a read at N+1. For the implied class (code 0), that read is a dead cycle and the last cycle, and the next fetch is again at N+1.
- R3: The kind output uses these codes: 0 fetch, 1 dead read, 2 operand read, 3 stack write, 4 stack read, 5 vector read. Exactly one of the read and write strobes is high on every cycle.
- R4: Push accumulator (code 1) and push status (code 2) take three cycles: fetch, dead read, then a write of the pushed value at 0x0100+SP. The write is followed by SP minus one.
- R5: Pull accumulator (code 3) and pull status (code 4) take four cycles: fetch, dead read, a dead read at 0x0100+SP, then a read at 0x0100+SP+1 with the matching load strobe. SP then holds SP+1.
- R6: Call (code 5) takes six cycles: fetch, operand read of the low target byte, dead read at 0x0100+SP, push of the PC high byte, push of the PC low byte, then operand read of the high target byte. The pushed PC is the address of the high target byte. The next fetch is at the target.
- R7: Return from subroutine (code 6) takes six cycles: fetch, dead read, dead read at 0x0100+SP, pull of the low byte, pull of the high byte, then a dead read at the pulled address. The next fetch is at the pulled address plus one.
- R8: Return from interrupt (code 7) takes six cycles: fetch, dead read, dead read at 0x0100+SP, pull of status with the status load strobe, pull of the PC low byte, then pull of the PC high byte. The next fetch is at the pulled address.
- R9: Software interrupt (code 8) takes seven cycles: fetch, dead read, pushes of PC high, PC low and the status input, then reads at 0xFFFE (low byte) and 0xFFFF (high byte). The pushed PC is the fetch address plus one. The next fetch is at the vector.
- R10: The done output is high only on the last cycle of an instruction, and the cycle after done is always an opcode fetch.
- R11: Class codes 9 to 15 behave exactly like the implied class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_class | input | 4 | Instruction class decoded from the byte read in the fetch cycle |
| bus_rdata | input | 8 | Read data for the current address |
| acc_in | input | 8 | Accumulator value for pushes |
| stat_in | input | 8 | Status value for pushes |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_we | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_kind | output | 3 | Kind of the current bus action |
| load_acc | output | 1 | The read data is the pulled accumulator |
| load_stat | output | 1 | The read data is the pulled status |
| instr_done | output | 1 | Last cycle of the instruction |
| pc_o | output | 16 | Current program counter |
| sp_o | output | 8 | Current stack pointer |

## Verification
A step counter or class register holding the wrong value shows up within one cycle as a wrong bus kind, a misplaced done pulse, or a write where a dead read was expected. Such an error is caught in the same cycle the kind, address and strobes are compared. A stack pointer off by one stays hidden until the next stack access, where it moves the address by one byte, and the return tests turn that into a wrong fetch address a few cycles later. Running a call followed by a return, and an interrupt followed by a return from interrupt, carries the pushed bytes back to the program counter. A fault in pointer direction or byte order therefore shows as a fetch from the wrong address.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;
  localparam int STEP_W = 3;

  typedef enum logic [3:0] {
    C_IMPL  = 4'd0,
    C_PUSHA = 4'd1,
    C_PUSHP = 4'd2,
    C_PULLA = 4'd3,
    C_PULLP = 4'd4,
    C_CALL  = 4'd5,
    C_RETS  = 4'd6,
    C_RETI  = 4'd7,
    C_SWI   = 4'd8
  } iclass_e;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_DEAD  = 3'd1,
    K_OPND  = 3'd2,
    K_SWR   = 3'd3,
    K_SRD   = 3'd4,
    K_VEC   = 3'd5
  } bkind_e;

  typedef enum logic [2:0] {
    A_PC  = 3'd0,
    A_SP  = 3'd1,
    A_SP1 = 3'd2,
    A_VLO = 3'd3,
    A_VHI = 3'd4
  } asel_e;

  typedef enum logic [1:0] {
    W_ACC  = 2'd0,
    W_STAT = 2'd1,
    W_PCH  = 2'd2,
    W_PCL  = 2'd3
  } wsel_e;

  typedef struct packed {
    bkind_e kind;
    asel_e  asel;
    wsel_e  wsel;
    logic   sp_up;
    logic   sp_dn;
    logic   pc_inc;
    logic   pc_jump;
    logic   lo_cap;
    logic   ld_a;
    logic   ld_p;
    logic   last;
  } act_t;
endpackage

// File: rtl/seq_step.sv
module seq_step
  import stkseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_class,
  input  logic              last,
  output logic [STEP_W-1:0] step,
  output iclass_e           cls
);
  localparam logic [3:0] MAX_CODE = 4'd8;

  logic [STEP_W-1:0] step_d;
  iclass_e           cls_d;
  logic              cls_en;

  always_comb begin
    step_d = last ? '0 : step + STEP_W'(1);
    cls_en = (step == '0);
    cls_d  = (op_class <= MAX_CODE) ? iclass_e'(op_class) : C_IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
      cls  <= C_IMPL;
    end else begin
      step <= step_d;
      if (cls_en) cls <= cls_d;
    end
  end
endmodule

// File: rtl/seq_plan.sv
module seq_plan
  import stkseq_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  iclass_e           cls,
  output act_t              act
);
  always_comb begin
    act = '{kind: K_DEAD, asel: A_PC, wsel: W_ACC, default: 1'b0};
    if (step == '0) begin
      act.kind   = K_FETCH;
      act.pc_inc = 1'b1;
    end else begin
      unique case (cls)
        C_PUSHA, C_PUSHP: begin
          if (step == 3'd2) begin
            act.kind  = K_SWR;
            act.asel  = A_SP;
            act.wsel  = (cls == C_PUSHA) ? W_ACC : W_STAT;
            act.sp_dn = 1'b1;
            act.last  = 1'b1;
          end
        end
        C_PULLA, C_PULLP: begin
          if (step == 3'd2) act.asel = A_SP;
          if (step == 3'd3) begin
            act.kind  = K_SRD;
            act.asel  = A_SP1;
            act.sp_up = 1'b1;
            act.ld_a  = (cls == C_PULLA);
            act.ld_p  = (cls == C_PULLP);
            act.last  = 1'b1;
          end
        end
        C_CALL: begin
          case (step)
            3'd1: begin act.kind = K_OPND; act.pc_inc = 1'b1; act.lo_cap = 1'b1; end
            3'd2: act.asel = A_SP;
            3'd3: begin act.kind = K_SWR; act.asel = A_SP; act.wsel = W_PCH; act.sp_dn = 1'b1; end
            3'd4: begin act.kind = K_SWR; act.asel = A_SP; act.wsel = W_PCL; act.sp_dn = 1'b1; end
            default: begin act.kind = K_OPND; act.pc_jump = 1'b1; act.last = 1'b1; end
          endcase
        end
        C_RETS: begin
          case (step)
            3'd1: act.asel = A_PC;
            3'd2: act.asel = A_SP;
            3'd3: begin act.kind = K_SRD; act.asel = A_SP1; act.sp_up = 1'b1; act.lo_cap = 1'b1; end
            3'd4: begin act.kind = K_SRD; act.asel = A_SP1; act.sp_up = 1'b1; act.pc_jump = 1'b1; end
            default: begin act.pc_inc = 1'b1; act.last = 1'b1; end
          endcase
        end
        C_RETI: begin
          case (step)
            3'd1: act.asel = A_PC;
            3'd2: act.asel = A_SP;
            3'd3: begin act.kind = K_SRD; act.asel = A_SP1; act.sp_up = 1'b1; act.ld_p = 1'b1; end
            3'd4: begin act.kind = K_SRD; act.asel = A_SP1; act.sp_up = 1'b1; act.lo_cap = 1'b1; end
            default: begin
              act.kind = K_SRD; act.asel = A_SP1; act.sp_up = 1'b1;
              act.pc_jump = 1'b1; act.last = 1'b1;
            end
          endcase
        end
        C_SWI: begin
          case (step)
            3'd1: act.asel = A_PC;
            3'd2: begin act.kind = K_SWR; act.asel = A_SP; act.wsel = W_PCH;  act.sp_dn = 1'b1; end
            3'd3: begin act.kind = K_SWR; act.asel = A_SP; act.wsel = W_PCL;  act.sp_dn = 1'b1; end
            3'd4: begin act.kind = K_SWR; act.asel = A_SP; act.wsel = W_STAT; act.sp_dn = 1'b1; end
            3'd5: begin act.kind = K_VEC; act.asel = A_VLO; act.lo_cap = 1'b1; end
            default: begin act.kind = K_VEC; act.asel = A_VHI; act.pc_jump = 1'b1; act.last = 1'b1; end
          endcase
        end
        default: act.last = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/seq_path.sv
module seq_path
  import stkseq_pkg::*;
#(
  parameter logic [15:0] RESET_PC   = 16'h0200,
  parameter logic [7:0]  RESET_SP   = 8'hFD,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VECTOR     = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  act_t        act,
  input  logic [7:0]  rdata,
  input  logic [7:0]  acc_in,
  input  logic [7:0]  stat_in,
  output logic [15:0] addr,
  output logic [7:0]  wdata,
  output logic [15:0] pc,
  output logic [7:0]  sp
);
  localparam logic [15:0] VECTOR_HI = VECTOR + 16'd1;

  logic [15:0] pc_d;
  logic [7:0]  sp_d;
  logic [7:0]  lo_q;
  logic        pc_en, sp_en, lo_en;

  always_comb begin
    pc_en = act.pc_jump | act.pc_inc;
    pc_d  = act.pc_jump ? {rdata, lo_q} : pc + 16'd1;
    sp_en = act.sp_up | act.sp_dn;
    sp_d  = act.sp_up ? sp + 8'd1 : sp - 8'd1;
    lo_en = act.lo_cap;
    unique case (act.asel)
      A_SP:    addr = {STACK_PAGE, sp};
      A_SP1:   addr = {STACK_PAGE, sp + 8'd1};
      A_VLO:   addr = VECTOR;
      A_VHI:   addr = VECTOR_HI;
      default: addr = pc;
    endcase
    unique case (act.wsel)
      W_STAT:  wdata = stat_in;
      W_PCH:   wdata = pc[15:8];
      W_PCL:   wdata = pc[7:0];
      default: wdata = acc_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= RESET_PC;
      sp   <= RESET_SP;
      lo_q <= '0;
    end else begin
      if (pc_en) pc   <= pc_d;
      if (sp_en) sp   <= sp_d;
      if (lo_en) lo_q <= rdata;
    end
  end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stkseq_pkg::*;
#(
  parameter logic [15:0] RESET_PC   = 16'h0200,
  parameter logic [7:0]  RESET_SP   = 8'hFD,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VECTOR     = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  op_class,
  input  logic [7:0]  bus_rdata,
  input  logic [7:0]  acc_in,
  input  logic [7:0]  stat_in,
  output logic [15:0] bus_addr,
  output logic        bus_rd,
  output logic        bus_we,
  output logic [7:0]  bus_wdata,
  output logic [2:0]  bus_kind,
  output logic        load_acc,
  output logic        load_stat,
  output logic        instr_done,
  output logic [15:0] pc_o,
  output logic [7:0]  sp_o
);
  logic [STEP_W-1:0] step;
  iclass_e           cls;
  act_t              act;

  seq_step u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_class (op_class),
    .last     (act.last),
    .step     (step),
    .cls      (cls)
  );

  seq_plan u_plan (
    .step (step),
    .cls  (cls),
    .act  (act)
  );

  seq_path #(
    .RESET_PC   (RESET_PC),
    .RESET_SP   (RESET_SP),
    .STACK_PAGE (STACK_PAGE),
    .VECTOR     (VECTOR)
  ) u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .rdata   (bus_rdata),
    .acc_in  (acc_in),
    .stat_in (stat_in),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .pc      (pc_o),
    .sp      (sp_o)
  );

  assign bus_kind   = act.kind;
  assign bus_we     = (act.kind == K_SWR);
  assign bus_rd     = (act.kind != K_SWR);
  assign load_acc   = act.ld_a;
  assign load_stat  = act.ld_p;
  assign instr_done = act.last;
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk
  import stkseq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  kind,
  input logic [15:0] addr,
  input logic        rd,
  input logic        we,
  input logic        done,
  input logic [7:0]  sp
);
  // R2: the cycle after a fetch reads the next address
  assert_fetch_then_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_FETCH) |=> (rd && (kind == K_DEAD || kind == K_OPND) && addr == $past(addr) + 16'd1));

  // R3: exactly one strobe active
  assert_rw_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd != we);

  // R4: a stack write lowers the pointer by one
  assert_push_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (sp == $past(sp) - 8'd1));

  // R5: a stack read raises the pointer by one
  assert_pull_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_SRD) |=> (sp == $past(sp) + 8'd1));

  // R5: stack traffic stays in the stack page
  assert_stack_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_SWR || kind == K_SRD) |-> (addr[15:8] == 8'h01));

  // R9: vector reads hit the top two bytes
  assert_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_VEC) |-> (addr[15:1] == 15'h7FFF));

  // R10: done is followed by a fetch and never falls on a fetch
  assert_done_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (kind == K_FETCH));
  assert_fetch_not_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_FETCH) |-> !done);
endmodule

bind stack_seq stack_seq_chk i_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .kind  (bus_kind),
  .addr  (bus_addr),
  .rd    (bus_rd),
  .we    (bus_we),
  .done  (instr_done),
  .sp    (sp_o)
);

// File: tb/test_stack_seq.sv
module test_stack_seq;
  localparam int CLK_P = 10;
  localparam logic [7:0] ACC  = 8'h5A;
  localparam logic [7:0] STAT = 8'hC3;

  typedef struct {
    logic [2:0]  k;
    logic [15:0] a;
    logic        w;
    logic [7:0]  d;
    logic        dn;
    logic        la;
    logic        lp;
    string       rq;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem [0:1023];
  logic [15:0] bus_addr;
  logic        bus_rd, bus_we, load_acc, load_stat, instr_done;
  logic [7:0]  bus_wdata, sp_o;
  logic [2:0]  bus_kind;
  logic [15:0] pc_o;
  logic [7:0]  bus_rdata;
  logic [3:0]  op_class;

  item_t       q[$];
  int          checks = 0;
  int          errors = 0;
  logic        mon_done = 1'b0;
  logic [15:0] m_pc = 16'h0200;
  logic [7:0]  m_sp = 8'hFD;
  logic [7:0]  m_stk [0:255];

  always #(CLK_P/2) clk = ~clk;

  assign bus_rdata = mem[bus_addr[9:0]];
  assign op_class  = bus_rdata[3:0];

  always @(posedge clk) if (bus_we) mem[bus_addr[9:0]] <= bus_wdata;

  stack_seq i_stack_seq (
    .clk(clk), .rst_n(rst_n), .op_class(op_class), .bus_rdata(bus_rdata),
    .acc_in(ACC), .stat_in(STAT), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_kind(bus_kind),
    .load_acc(load_acc), .load_stat(load_stat), .instr_done(instr_done),
    .pc_o(pc_o), .sp_o(sp_o)
  );

  task automatic add(input logic [2:0] k, input logic [15:0] a, input logic w,
                     input logic [7:0] d, input logic dn, input logic la,
                     input logic lp, input string rq);
    item_t it;
    it.k = k; it.a = a; it.w = w; it.d = d; it.dn = dn; it.la = la; it.lp = lp; it.rq = rq;
    q.push_back(it);
  endtask

  task automatic mpush(input logic [7:0] d, input logic dn, input string rq);
    add(3'd3, {8'h01, m_sp}, 1'b1, d, dn, 1'b0, 1'b0, rq);
    m_stk[m_sp] = d;
    m_sp = m_sp - 8'd1;
  endtask

  task automatic mpull(output logic [7:0] d, input logic dn, input logic la,
                       input logic lp, input string rq);
    m_sp = m_sp + 8'd1;
    d = m_stk[m_sp];
    add(3'd4, {8'h01, m_sp}, 1'b0, 8'h00, dn, la, lp, rq);
  endtask

  // driver: expected bus cycles per instruction, from the requirements
  task automatic model_instr(input logic [3:0] c);
    logic [7:0] lo, hi, sk;
    add(3'd0, m_pc, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, (c > 4'd8) ? "R11" : "R10");
    m_pc = m_pc + 16'd1;
    case (c)
      4'd1, 4'd2: begin
        add(3'd1, m_pc, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R4");
        mpush((c == 4'd1) ? ACC : STAT, 1'b1, "R4");
      end
      4'd3, 4'd4: begin
        add(3'd1, m_pc, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R5");
        add(3'd1, {8'h01, m_sp}, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R5");
        mpull(sk, 1'b1, c == 4'd3, c == 4'd4, "R5");
      end
      4'd5: begin
        lo = mem[m_pc[9:0]];
        add(3'd2, m_pc, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R6");
        m_pc = m_pc + 16'd1;
        add(3'd1, {8'h01, m_sp}, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R6");
        mpush(m_pc[15:8], 1'b0, "R6");
        mpush(m_pc[7:0], 1'b0, "R6");
        hi = mem[m_pc[9:0]];
        add(3'd2, m_pc, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R6");
        m_pc = {hi, lo};
      end
      4'd6: begin
        add(3'd1, m_pc, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R7");
        add(3'd1, {8'h01, m_sp}, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R7");
        mpull(lo, 1'b0, 1'b0, 1'b0, "R7");
        mpull(hi, 1'b0, 1'b0, 1'b0, "R7");
        m_pc = {hi, lo};
        add(3'd1, m_pc, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R7");
        m_pc = m_pc + 16'd1;
      end
      4'd7: begin
        add(3'd1, m_pc, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R8");
        add(3'd1, {8'h01, m_sp}, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R8");
        mpull(sk, 1'b0, 1'b0, 1'b1, "R8");
        mpull(lo, 1'b0, 1'b0, 1'b0, "R8");
        mpull(hi, 1'b1, 1'b0, 1'b0, "R8");
        m_pc = {hi, lo};
      end
      4'd8: begin
        add(3'd1, m_pc, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R9");
        mpush(m_pc[15:8], 1'b0, "R9");
        mpush(m_pc[7:0], 1'b0, "R9");
        mpush(STAT, 1'b0, "R9");
        lo = mem[10'h3FE];
        hi = mem[10'h3FF];
        add(3'd5, 16'hFFFE, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R9");
        add(3'd5, 16'hFFFF, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R9");
        m_pc = {hi, lo};
      end
      default:
        add(3'd1, m_pc, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, (c == 4'd0) ? "R2" : "R11");
    endcase
  endtask

  task automatic chk(input logic ok, input string rq, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", rq, msg);
    end
  endtask

  // monitor: pops expected cycles and compares at mid-cycle
  initial begin
    item_t e;
    @(posedge rst_n);
    while (q.size() > 0) begin
      #(CLK_P/4);
      e = q.pop_front();
      chk(bus_kind == e.k && bus_addr == e.a && bus_we == e.w && bus_rd == !e.w &&
          (!e.w || bus_wdata == e.d) && instr_done == e.dn &&
          load_acc == e.la && load_stat == e.lp, e.rq,
          $sformatf("kind=%0d addr=%h we=%b rd=%b wd=%h done=%b la=%b lp=%b expected kind=%0d addr=%h we=%b wd=%h done=%b la=%b lp=%b",
                    bus_kind, bus_addr, bus_we, bus_rd, bus_wdata, instr_done, load_acc, load_stat,
                    e.k, e.a, e.w, e.d, e.dn, e.la, e.lp));
      if (q.size() == 0)
        chk(sp_o == m_sp && pc_o == m_pc + 16'd0, "R7",
            $sformatf("sp=%h pc=%h expected sp=%h pc=%h", sp_o, pc_o, m_sp, m_pc));
      else
        @(negedge clk);
    end
    mon_done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    for (int i = 0; i < 256; i++) m_stk[i] = 8'h00;
    mem[10'h200] = 8'h00;  // implied
    mem[10'h201] = 8'h31;  // push acc
    mem[10'h202] = 8'h22;  // push status
    mem[10'h203] = 8'h43;  // pull acc
    mem[10'h204] = 8'h54;  // pull status
    mem[10'h205] = 8'h05;  // call
    mem[10'h206] = 8'h40;
    mem[10'h207] = 8'h02;
    mem[10'h240] = 8'h06;  // return from subroutine
    mem[10'h208] = 8'h08;  // software interrupt
    mem[10'h280] = 8'h07;  // return from interrupt
    mem[10'h209] = 8'h0F;  // unused code
    mem[10'h20A] = 8'h00;
    mem[10'h3FE] = 8'h80;
    mem[10'h3FF] = 8'h02;
    repeat (11) model_instr(mem[m_pc[9:0]][3:0]);
    add(3'd0, m_pc, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R10");

    @(negedge clk);
    #1;
    chk(pc_o == 16'h0200 && sp_o == 8'hFD && !bus_we && bus_kind == 3'd0, "R1",
        $sformatf("pc=%h sp=%h we=%b kind=%0d expected pc=0200 sp=fd we=0 kind=0",
                  pc_o, sp_o, bus_we, bus_kind));
    @(negedge clk);
    #1;
    chk(bus_addr == 16'h0200 && !bus_we, "R1",
        $sformatf("addr=%h we=%b expected addr=0200 we=0", bus_addr, bus_we));
    @(negedge clk);
    rst_n = 1'b1;
    wait (mon_done);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule